// File: doc/BRIEF.md
# Line-Based Pixel Gap Removal Buffer

This block sits in a streaming video path whose valid pixels arrive unevenly: in bursts from a memory reader, or on every other clock from a camera link. Each cycle carries a vector of `PPC` pixels (1, 4 or 8 lanes of `PIX_W` bits) and one shared set of five control flags: line start, line end, frame start, frame end and valid. Only valid beats are kept. Each beat's pixels go into per-lane line memories and its four position flags go into a separate flag memory.

When the beat that carries the line-end flag has been stored, the line is complete. It is then replayed as one unbroken run of valid beats, starting a fixed three cycles after the input line-end cycle. Because every line is released at the same offset from its own line end, the spacing between lines at the output is the spacing between line ends at the input. Line and frame lengths, idle cycles included, therefore carry through unchanged.

Two line banks alternate, so the next line can be written while the previous one is replayed. The write position restarts at each line start. A line longer than `MAX_LINE` pixels is cut short and raises a sticky overflow flag. `MAX_LINE/PPC` must be a power of two.

Top module: `gapbuf_line`

## Requirements
- R1: After reset, `out_vld`, all output flags, `out_pix` and `ovf_sticky` are 0.
- R2: Only input beats with `in_vld`=1 are stored. Each output line carries exactly the valid beats of its input line, in input order, with the flags they had at the input.
- R3: The first beat of an output line (`out_hs`=1) appears exactly 3 cycles after the cycle in which the line-end beat (`in_vld`=1, `in_he`=1) was presented at the input. No beat of a line is emitted before that beat has been stored.
- R4: From `out_hs` up to and including `out_he`, `out_vld` is 1 on every cycle.
- R5: The number of cycles between two consecutive output line starts equals the number of cycles between the two corresponding input line-end beats.
- R6: On any cycle with `out_vld`=0, all four output flags and `out_pix` are 0.
- R7: `out_vs` appears only on a beat that was stored with the frame-start flag, normally the first beat of a line. `out_ve` appears only on a beat that was stored with the frame-end flag, normally the last beat of the last line.
- R8: A line with more than D = `MAX_LINE/PPC` valid beats is emitted as its first D-1 beats followed by its line-end beat. The other beats are discarded, and `ovf_sticky` goes to 1 and stays at 1 until reset.
- R9: Lane k of a beat sits at bits [k*PIX_W +: PIX_W] of both `in_pix` and `out_pix`. All lanes of a beat are kept together and share one flag set.
- R10: A valid beat with `in_hs`=1 restarts the line. Beats of an earlier line that never reached a line-end beat are never emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_pix | input | PPC*PIX_W | Input pixel vector, lane 0 in the low bits |
| in_vld | input | 1 | Input beat valid |
| in_hs | input | 1 | Input line start |
| in_he | input | 1 | Input line end |
| in_vs | input | 1 | Input frame start |
| in_ve | input | 1 | Input frame end |
| out_pix | output | PPC*PIX_W | Output pixel vector, 0 when not valid |
| out_vld | output | 1 | Output beat valid |
| out_hs | output | 1 | Output line start |
| out_he | output | 1 | Output line end |
| out_vs | output | 1 | Output frame start |
| out_ve | output | 1 | Output frame end |
| ovf_sticky | output | 1 | A line exceeded the configured maximum length |

## Verification
The assertions assume well-formed input lines: line and frame flags appear only on valid beats, and every line's first valid beat carries the line-start flag. They also assume that two input line ends are at least as many cycles apart as the number of beats in the earlier line, so one replay finishes before the next one starts. The stimulus respects this by following each line with an idle stretch longer than that line. Inside a line, the stimulus mixes bursts, strictly alternating beats and random gaps. It also places directed cases in between: a one-beat line, a line of exactly full depth, an abandoned line that has no line end, and an over-long line.

// File: rtl/gapbuf_pkg.sv
package gapbuf_pkg;

  typedef struct packed {
    logic hs;
    logic he;
    logic vs;
    logic ve;
  } gb_flags_t;

  // beats held per lane for one line
  function automatic int gb_lane_depth(int max_line, int ppc);
    return max_line / ppc;
  endfunction

  // line length recorded when the line-end beat lands at position pos
  function automatic int gb_line_len(int pos, int depth);
    return (pos >= depth) ? depth : pos + 1;
  endfunction

  // storage slot for a beat at position pos; only the line end may use a clipped slot
  function automatic int gb_slot(int pos, int depth);
    return (pos >= depth) ? depth - 1 : pos;
  endfunction

endpackage

// File: rtl/gapbuf_ram.sv
module gapbuf_ram #(
  parameter int W  = 8,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int N = 1 << AW;

  logic [W-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/gapbuf_wr.sv
module gapbuf_wr
  import gapbuf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic          in_hs,
  input  logic          in_he,
  output logic          wr_en,
  output logic [AW:0]   wr_addr,
  output logic          done,
  output logic [LW-1:0] done_len,
  output logic          done_bank,
  output logic          ovf
);
  logic [LW-1:0] wcnt;
  logic [LW-1:0] pos;
  logic          bank;
  logic          over;
  logic [AW-1:0] slot;

  assign pos     = in_hs ? '0 : wcnt;
  assign over    = pos >= LW'(DEPTH);
  assign slot    = AW'(gb_slot(int'(pos), DEPTH));
  assign wr_en   = in_vld && (!over || in_he);
  assign wr_addr = {bank, slot};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt      <= '0;
      bank      <= 1'b0;
      done      <= 1'b0;
      done_len  <= '0;
      done_bank <= 1'b0;
      ovf       <= 1'b0;
    end else begin
      done <= in_vld && in_he;
      if (in_vld && !over) wcnt <= pos + LW'(1);
      if (in_vld && over) ovf <= 1'b1;
      if (in_vld && in_he) begin
        done_len  <= LW'(gb_line_len(int'(pos), DEPTH));
        done_bank <= bank;
        bank      <= ~bank;
      end
    end
  end

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  p_len_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_len != '0) && (done_len <= LW'(DEPTH)));
  p_bank_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_bank != wr_addr[AW]));
endmodule

// File: rtl/gapbuf_rd.sv
module gapbuf_rd #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] start_len,
  input  logic          start_bank,
  output logic          rd_en,
  output logic [AW:0]   rd_addr,
  output logic          beat_vld
);
  logic          act;
  logic          bank;
  logic [LW-1:0] ptr;
  logic [LW-1:0] len;
  logic          last;

  assign last    = act && (ptr == len - LW'(1));
  assign rd_en   = act;
  assign rd_addr = {bank, ptr[AW-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act      <= 1'b0;
      bank     <= 1'b0;
      ptr      <= '0;
      len      <= '0;
      beat_vld <= 1'b0;
    end else begin
      beat_vld <= act;
      if (start) begin
        act  <= 1'b1;
        ptr  <= '0;
        len  <= start_len;
        bank <= start_bank;
      end else if (act) begin
        if (last) act <= 1'b0;
        else ptr <= ptr + LW'(1);
      end
    end
  end

  p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (!act || last));
  p_run_unbroken_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !last) |=> act);
endmodule

// File: rtl/gapbuf_line.sv
module gapbuf_line
  import gapbuf_pkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int PPC      = 4,
  parameter int MAX_LINE = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PPC*PIX_W-1:0] in_pix,
  input  logic                 in_vld,
  input  logic                 in_hs,
  input  logic                 in_he,
  input  logic                 in_vs,
  input  logic                 in_ve,
  output logic [PPC*PIX_W-1:0] out_pix,
  output logic                 out_vld,
  output logic                 out_hs,
  output logic                 out_he,
  output logic                 out_vs,
  output logic                 out_ve,
  output logic                 ovf_sticky
);
  localparam int DEPTH = gb_lane_depth(MAX_LINE, PPC);
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW    = $clog2(DEPTH + 1);

  logic          wr_en, rd_en, line_done, done_bank, beat_vld;
  logic [AW:0]   wr_addr, rd_addr;
  logic [LW-1:0] done_len;
  gb_flags_t     wflags, rflags;
  logic [PPC*PIX_W-1:0] rpix;

  assign wflags = '{hs: in_hs, he: in_he, vs: in_vs, ve: in_ve};

  gapbuf_wr #(.DEPTH(DEPTH), .AW(AW), .LW(LW)) u_wr (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_hs(in_hs), .in_he(in_he),
    .wr_en(wr_en), .wr_addr(wr_addr), .done(line_done), .done_len(done_len),
    .done_bank(done_bank), .ovf(ovf_sticky)
  );

  gapbuf_rd #(.DEPTH(DEPTH), .AW(AW), .LW(LW)) u_rd (
    .clk(clk), .rst_n(rst_n), .start(line_done), .start_len(done_len),
    .start_bank(done_bank), .rd_en(rd_en), .rd_addr(rd_addr), .beat_vld(beat_vld)
  );

  gapbuf_ram #(.W($bits(gb_flags_t)), .AW(AW + 1)) u_flag_ram (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wflags),
    .re(rd_en), .raddr(rd_addr), .rdata(rflags)
  );

  for (genvar k = 0; k < PPC; k++) begin : g_lane
    gapbuf_ram #(.W(PIX_W), .AW(AW + 1)) u_pix_ram (
      .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(in_pix[k*PIX_W +: PIX_W]),
      .re(rd_en), .raddr(rd_addr), .rdata(rpix[k*PIX_W +: PIX_W])
    );
  end

  assign out_vld = beat_vld;
  assign out_pix = beat_vld ? rpix : '0;
  assign out_hs  = beat_vld & rflags.hs;
  assign out_he  = beat_vld & rflags.he;
  assign out_vs  = beat_vld & rflags.vs;
  assign out_ve  = beat_vld & rflags.ve;

  p_contig_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !out_he) |=> out_vld);
  p_vs_at_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_vs |-> out_hs);
  p_line_head_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_vld) |-> out_hs);
endmodule

// File: tb/gapbuf_line_tb.sv
module gapbuf_line_tb;
  localparam int PIX_W = 8, PPC = 4, MAX_LINE = 64;
  localparam int D  = MAX_LINE / PPC;
  localparam int VW = PPC * PIX_W;

  typedef struct packed {
    logic [VW-1:0] pix;
    logic hs, he, vs, ve;
  } beat_t;

  logic clk = 0, rst_n = 0;
  logic [VW-1:0] in_pix = '0;
  logic in_vld = 0, in_hs = 0, in_he = 0, in_vs = 0, in_ve = 0;
  logic [VW-1:0] out_pix;
  logic out_vld, out_hs, out_he, out_vs, out_ve, ovf_sticky;

  gapbuf_line #(.PIX_W(PIX_W), .PPC(PPC), .MAX_LINE(MAX_LINE)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_pix(in_pix), .in_vld(in_vld), .in_hs(in_hs),
    .in_he(in_he), .in_vs(in_vs), .in_ve(in_ve), .out_pix(out_pix),
    .out_vld(out_vld), .out_hs(out_hs), .out_he(out_he), .out_vs(out_vs),
    .out_ve(out_ve), .ovf_sticky(ovf_sticky)
  );

  always #10 clk = ~clk;  // 50 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  bit finished = 0;
  beat_t exp_q[$];
  int    start_q[$];
  int    prev_out_hs = -1, prev_exp_hs = -1;
  logic  prev_vld = 0, prev_he = 0;
  bit    mon_on = 0;

  function automatic int expected_start(int he_cycle);
    return he_cycle + 3;
  endfunction

  function automatic bit beat_kept(int idx, int nb);
    return (nb <= D) || (idx < D - 1) || (idx == nb - 1);
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_vld = 0; in_hs = 0; in_he = 0; in_vs = 0; in_ve = 0;
      in_pix = VW'($urandom);
    end
  endtask

  // mode 0 burst, 1 every other cycle, 2 random gaps
  task automatic send_line(int nb, int mode, bit fs, bit fe, bit has_end);
    for (int i = 0; i < nb; i++) begin
      int gap;
      gap = (i == 0) ? 0 : (mode == 0) ? 0 : (mode == 1) ? 1 : int'($urandom % 4);
      if (gap > 0) idle(gap);
      @(negedge clk);
      in_vld = 1;
      in_pix = VW'($urandom);
      in_hs  = (i == 0);
      in_he  = has_end && (i == nb - 1);
      in_vs  = fs && (i == 0);
      in_ve  = fe && in_he;
      if (has_end && beat_kept(i, nb))
        exp_q.push_back('{pix: in_pix, hs: in_hs, he: in_he, vs: in_vs, ve: in_ve});
      if (in_he) start_q.push_back(expected_start(cyc));
    end
    idle(nb + 3 + int'($urandom % 5));
  endtask

  // output monitor
  always @(negedge clk) begin
    if (mon_on && !finished) begin
      if (out_vld) begin
        if (exp_q.size() == 0) chk(0, "R2 (unexpected beat)", 64'(out_pix), 0);
        else begin
          beat_t e, a;
          e = exp_q.pop_front();
          a = '{pix: out_pix, hs: out_hs, he: out_he, vs: out_vs, ve: out_ve};
          chk(a == e, "R2 R7 R9 beat", 64'(a), 64'(e));
        end
      end else begin
        chk(!out_hs && !out_he && !out_vs && !out_ve && out_pix == '0, "R6",
            64'({out_hs, out_he, out_vs, out_ve}), 0);
      end
      if (prev_vld && !prev_he) chk(out_vld, "R4 gap inside line", 64'(out_vld), 1);
      if (out_hs) begin
        if (start_q.size() == 0) chk(0, "R3 (unexpected line)", 64'(cyc), 0);
        else begin
          int es;
          es = start_q.pop_front();
          chk(cyc == es, "R3 line start cycle", 64'(cyc), 64'(es));
          if (prev_out_hs >= 0)
            chk(cyc - prev_out_hs == es - prev_exp_hs, "R5 line spacing",
                64'(cyc - prev_out_hs), 64'(es - prev_exp_hs));
          prev_out_hs = cyc;
          prev_exp_hs = es;
        end
      end
      prev_vld = out_vld;
      prev_he  = out_he;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    idle(3);
    @(negedge clk);
    chk(!out_vld && !out_hs && !out_he && !out_vs && !out_ve && out_pix == '0 && !ovf_sticky,
        "R1 reset", 64'({out_vld, out_hs, out_he, out_vs, out_ve, ovf_sticky}), 0);
    rst_n = 1;
    mon_on = 1;
    idle(2);

    // directed: burst, alternate, single beat, exactly full depth
    send_line(6, 0, 1, 0, 1);
    send_line(6, 1, 0, 0, 1);
    send_line(1, 2, 0, 0, 1);
    send_line(D, 2, 0, 1, 1);  // R7 frame end on last line

    // R10: abandoned line then a complete one
    send_line(5, 0, 1, 0, 0);
    send_line(4, 1, 0, 1, 1);

    // random frames
    for (int f = 0; f < 4; f++) begin
      int nl;
      nl = 3 + int'($urandom % 4);
      for (int l = 0; l < nl; l++)
        send_line(1 + int'($urandom % D), int'($urandom % 3), l == 0, l == nl - 1, 1);
    end

    idle(5);
    chk(!ovf_sticky, "R8 no overflow yet", 64'(ovf_sticky), 0);
    // R8: over-long line
    send_line(D + 5, 2, 1, 1, 1);
    idle(10);
    chk(ovf_sticky, "R8 overflow flagged", 64'(ovf_sticky), 1);
    send_line(3, 0, 1, 1, 1);
    idle(10);
    chk(ovf_sticky, "R8 overflow sticky", 64'(ovf_sticky), 1);
    chk(exp_q.size() == 0 && start_q.size() == 0, "R2 all beats emitted",
        64'(exp_q.size()), 0);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule